// File: doc/BRIEF.md
# Predicate Guard Unit

This block holds a bank of one-bit condition flags and uses them to qualify the register writeback of issued operations. A compare operation delivers a single condition bit and two flag indices. The first named flag receives the condition and the second receives its inverse, both in the same clock edge. Every issued operation in each slot names one guard flag. The block passes that slot's writeback enable through only when the named flag is set. An operation whose guard is clear therefore retires as a no-op.

Flag 0 is permanently set, so an unguarded operation simply names it. Because a single compare produces a complementary pair, the two arms of an if/else can be placed in parallel slots of one instruction. Exactly one of the two arms then commits.

Flag updates are registered. A lookup sees the flag values as they stood before the current edge, with no same-cycle forwarding. The block has no state machine: its only state is the flag bank, cleared by an asynchronous active-low reset.

Top module: `pred_guard_unit`

## Requirements
- R1: While and after reset, every flag with index 1 to NUM_PRED-1 reads 0, so a slot naming one of them drives `slot_wen_out` low even when its `slot_wen_in` is high.
- R2: Flag 0 always reads 1: a slot naming index 0 drives `slot_wen_out` equal to its `slot_wen_in`, in every cycle including reset.
- R3: A compare that targets index 0 with either destination leaves flag 0 reading 1.
- R4: On a clock edge with `cmp_valid` high, flag `cmp_dst_true` takes `cmp_cond` and flag `cmp_dst_false` takes the inverse of `cmp_cond`.
- R5: When `cmp_dst_true` equals `cmp_dst_false`, that flag takes `cmp_cond`.
- R6: A flag written at edge t is seen by lookups only after that edge; during the cycle in which the compare is presented, lookups return the old value.
- R7: `slot_wen_out[s]` is high only if `slot_wen_in[s]` is high; with `slot_wen_in[s]` low the output is low whatever the flag holds.
- R8: Two slots guarded by the true and false flags of one compare with distinct nonzero indices, both with `slot_wen_in` high, produce exactly one high `slot_wen_out` bit.
- R9: With `cmp_valid` low, `cmp_cond` and both destination indices have no effect on any flag.
- R10: A compare changes no flag other than its two destinations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flag bank |
| cmp_valid | input | 1 | A compare result is presented this cycle |
| cmp_cond | input | 1 | Condition produced by the compare |
| cmp_dst_true | input | IDX_W | Flag that receives the condition |
| cmp_dst_false | input | IDX_W | Flag that receives the inverted condition |
| slot_qp | input | NUM_SLOTS*IDX_W | Guard flag index per slot; slot s occupies bits [s*IDX_W +: IDX_W] |
| slot_wen_in | input | NUM_SLOTS | Raw writeback enable per slot; bit s is slot s |
| slot_wen_out | output | NUM_SLOTS | Writeback enable after qualification by the guard flag |

## Verification
The bench builds the block with its defaults: 64 flags (6-bit indices) and two slots. Two slots are what make the complementary if/else pairing and a double lookup of one flag observable in a single cycle. A 64-entry bank puts the top index 63 in reach, so the bench sweeps all indices after reset and writes the highest flag to exercise the end of the decode.

// File: rtl/pred_pkg.sv
package pred_pkg;

    localparam int PRED_COUNT_DEF = 64;
    localparam int SLOT_COUNT_DEF = 2;

    typedef struct packed {
        logic en;
        logic val;
    } pred_upd_t;

endpackage

// File: rtl/pred_wr_decode.sv
module pred_wr_decode #(
    parameter int NUM_PRED = pred_pkg::PRED_COUNT_DEF,
    localparam int IDX_W = $clog2(NUM_PRED)
) (
    input  logic                        cmp_valid,
    input  logic                        cmp_cond,
    input  logic [IDX_W-1:0]            cmp_dst_true,
    input  logic [IDX_W-1:0]            cmp_dst_false,
    output pred_pkg::pred_upd_t [NUM_PRED-1:0] upd
);

    // Flag 0 is constant: it never receives an update.
    assign upd[0] = '0;

    for (genvar r = 1; r < NUM_PRED; r++) begin : g_dec
        logic hit_t;
        logic hit_f;
        assign hit_t = cmp_valid && (cmp_dst_true  == IDX_W'(r));
        assign hit_f = cmp_valid && (cmp_dst_false == IDX_W'(r));
        // The true destination has priority when both name this flag.
        assign upd[r].en  = hit_t || hit_f;
        assign upd[r].val = hit_t ? cmp_cond : ~cmp_cond;
    end

endmodule

// File: rtl/pred_bank.sv
module pred_bank #(
    parameter int NUM_PRED = pred_pkg::PRED_COUNT_DEF
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  pred_pkg::pred_upd_t [NUM_PRED-1:0]  upd,
    output logic [NUM_PRED-1:0]                 flags
);

    assign flags[0] = 1'b1;

    for (genvar r = 1; r < NUM_PRED; r++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[r] <= 1'b0;
            end else if (upd[r].en) begin
                flags[r] <= upd[r].val;
            end
        end
    end

    logic unused_upd0;
    assign unused_upd0 = ^upd[0];

endmodule

// File: rtl/pred_squash.sv
module pred_squash #(
    parameter int NUM_PRED = pred_pkg::PRED_COUNT_DEF,
    localparam int IDX_W = $clog2(NUM_PRED)
) (
    input  logic [NUM_PRED-1:0] flags,
    input  logic [IDX_W-1:0]    qp,
    input  logic                wen_in,
    output logic                wen_out
);

    logic in_range;
    logic guard;

    assign in_range = int'(qp) < NUM_PRED;
    assign guard    = in_range ? flags[qp] : 1'b0;
    assign wen_out  = wen_in & guard;

endmodule

// File: rtl/pred_guard_unit.sv
module pred_guard_unit #(
    parameter int NUM_PRED  = pred_pkg::PRED_COUNT_DEF,
    parameter int NUM_SLOTS = pred_pkg::SLOT_COUNT_DEF,
    localparam int IDX_W = $clog2(NUM_PRED)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmp_valid,
    input  logic                       cmp_cond,
    input  logic [IDX_W-1:0]           cmp_dst_true,
    input  logic [IDX_W-1:0]           cmp_dst_false,
    input  logic [NUM_SLOTS*IDX_W-1:0] slot_qp,
    input  logic [NUM_SLOTS-1:0]       slot_wen_in,
    output logic [NUM_SLOTS-1:0]       slot_wen_out
);

    pred_pkg::pred_upd_t [NUM_PRED-1:0] upd;
    logic [NUM_PRED-1:0]                flags;

    pred_wr_decode #(.NUM_PRED(NUM_PRED)) u_dec (
        .cmp_valid     (cmp_valid),
        .cmp_cond      (cmp_cond),
        .cmp_dst_true  (cmp_dst_true),
        .cmp_dst_false (cmp_dst_false),
        .upd           (upd)
    );

    pred_bank #(.NUM_PRED(NUM_PRED)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (upd),
        .flags (flags)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        pred_squash #(.NUM_PRED(NUM_PRED)) u_sq (
            .flags   (flags),
            .qp      (slot_qp[s*IDX_W +: IDX_W]),
            .wen_in  (slot_wen_in[s]),
            .wen_out (slot_wen_out[s])
        );
    end

endmodule

// File: rtl/pred_guard_checker.sv
module pred_guard_checker #(
    parameter int NUM_PRED  = pred_pkg::PRED_COUNT_DEF,
    parameter int NUM_SLOTS = pred_pkg::SLOT_COUNT_DEF,
    localparam int IDX_W = $clog2(NUM_PRED)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cmp_valid,
    input logic                       cmp_cond,
    input logic [IDX_W-1:0]           cmp_dst_true,
    input logic [IDX_W-1:0]           cmp_dst_false,
    input logic [NUM_SLOTS*IDX_W-1:0] slot_qp,
    input logic [NUM_SLOTS-1:0]       slot_wen_in,
    input logic [NUM_SLOTS-1:0]       slot_wen_out
);

    logic [IDX_W-1:0] qp0;
    assign qp0 = slot_qp[IDX_W-1:0];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot_chk
        p_zero_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_qp[s*IDX_W +: IDX_W] == '0) |-> (slot_wen_out[s] == slot_wen_in[s]));

        p_no_raw_wen_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !slot_wen_in[s] |-> !slot_wen_out[s]);
    end

    p_true_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_dst_true != '0) |=>
        ((qp0 == $past(cmp_dst_true) && slot_wen_in[0]) ?
            (slot_wen_out[0] == $past(cmp_cond)) : 1'b1));

    p_false_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_dst_false != '0 && cmp_dst_false != cmp_dst_true) |=>
        ((qp0 == $past(cmp_dst_false) && slot_wen_in[0]) ?
            (slot_wen_out[0] == !$past(cmp_cond)) : 1'b1));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=>
        ((slot_qp == $past(slot_qp) && slot_wen_in == $past(slot_wen_in)) ?
            (slot_wen_out == $past(slot_wen_out)) : 1'b1));

    if (NUM_SLOTS >= 2) begin : g_pair_chk
        logic [IDX_W-1:0] qp1;
        assign qp1 = slot_qp[2*IDX_W-1:IDX_W];

        p_one_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_valid && cmp_dst_true != '0 && cmp_dst_false != '0 &&
             cmp_dst_true != cmp_dst_false) |=>
            ((qp0 == $past(cmp_dst_true) && qp1 == $past(cmp_dst_false) &&
              slot_wen_in[1:0] == 2'b11) ?
                ($countones(slot_wen_out[1:0]) == 1) : 1'b1));
    end

endmodule

bind pred_guard_unit pred_guard_checker #(
    .NUM_PRED  (NUM_PRED),
    .NUM_SLOTS (NUM_SLOTS)
) u_pred_guard_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmp_valid     (cmp_valid),
    .cmp_cond      (cmp_cond),
    .cmp_dst_true  (cmp_dst_true),
    .cmp_dst_false (cmp_dst_false),
    .slot_qp       (slot_qp),
    .slot_wen_in   (slot_wen_in),
    .slot_wen_out  (slot_wen_out)
);

// File: tb/tb_pred_guard_unit.sv
module tb_pred_guard_unit;

    localparam int NP   = 64;
    localparam int NS   = 2;
    localparam int IW   = 6;
    localparam int NVEC = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmp_valid = 1'b0;
    logic          cmp_cond = 1'b0;
    logic [IW-1:0] cmp_dst_true = '0;
    logic [IW-1:0] cmp_dst_false = '0;
    logic [NS*IW-1:0] slot_qp = '0;
    logic [NS-1:0] slot_wen_in = '0;
    logic [NS-1:0] slot_wen_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    pred_guard_unit #(.NUM_PRED(NP), .NUM_SLOTS(NS)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmp_valid     (cmp_valid),
        .cmp_cond      (cmp_cond),
        .cmp_dst_true  (cmp_dst_true),
        .cmp_dst_false (cmp_dst_false),
        .slot_qp       (slot_qp),
        .slot_wen_in   (slot_wen_in),
        .slot_wen_out  (slot_wen_out)
    );

    // Fields: {valid, cond, dst_true, dst_false, qp0, qp1, wen_in[1:0], expect[1:0]}
    // A compare in vector k is seen by lookups from vector k+1 on.
    localparam logic [29:0] VEC [NVEC] = '{
        {1'b0,1'b0,6'd0, 6'd0, 6'd5, 6'd6, 2'b11,2'b00}, // 0  R1 cleared flags
        {1'b1,1'b1,6'd5, 6'd6, 6'd5, 6'd6, 2'b11,2'b00}, // 1  R6 old value this cycle
        {1'b0,1'b0,6'd0, 6'd0, 6'd5, 6'd6, 2'b11,2'b01}, // 2  R4 p5=1 p6=0
        {1'b1,1'b0,6'd5, 6'd6, 6'd5, 6'd6, 2'b11,2'b01}, // 3  R6 still old
        {1'b0,1'b0,6'd0, 6'd0, 6'd5, 6'd6, 2'b11,2'b10}, // 4  R4 p5=0 p6=1
        {1'b0,1'b0,6'd0, 6'd0, 6'd0, 6'd6, 2'b00,2'b00}, // 5  R7 raw enables low
        {1'b1,1'b0,6'd0, 6'd7, 6'd0, 6'd7, 2'b11,2'b01}, // 6  R3 write 0 to flag 0
        {1'b0,1'b0,6'd0, 6'd0, 6'd0, 6'd7, 2'b11,2'b11}, // 7  R3 flag 0 still 1, p7=1
        {1'b1,1'b1,6'd9, 6'd9, 6'd9, 6'd5, 2'b11,2'b00}, // 8  R5 same index
        {1'b0,1'b0,6'd0, 6'd0, 6'd9, 6'd6, 2'b11,2'b11}, // 9  R5 p9 took cond=1
        {1'b1,1'b0,6'd9, 6'd9, 6'd9, 6'd0, 2'b10,2'b10}, // 10 R7 slot0 raw low
        {1'b0,1'b0,6'd0, 6'd0, 6'd9, 6'd63,2'b11,2'b00}, // 11 R5 p9 took cond=0
        {1'b1,1'b1,6'd63,6'd1, 6'd5, 6'd7, 2'b11,2'b10}, // 12 R10 p5,p7 kept
        {1'b0,1'b0,6'd0, 6'd0, 6'd63,6'd1, 2'b11,2'b01}, // 13 R8 one arm commits
        {1'b0,1'b0,6'd63,6'd1, 6'd63,6'd1, 2'b11,2'b01}, // 14 R9 idle compare
        {1'b0,1'b0,6'd0, 6'd0, 6'd63,6'd1, 2'b11,2'b01}  // 15 R9 nothing changed
    };

    task automatic check(input logic [NS-1:0] exp, input string req, input int idx);
        n_tests++;
        if (slot_wen_out !== exp) begin
            n_fail++;
            $display("FAIL %s step %0d: slot_wen_out=%b expected %b", req, idx, slot_wen_out, exp);
        end
    endtask

    task automatic drive(input logic v, input logic c, input logic [IW-1:0] dt,
                         input logic [IW-1:0] df, input logic [IW-1:0] q0,
                         input logic [IW-1:0] q1, input logic [NS-1:0] w);
        @(negedge clk);
        cmp_valid     = v;
        cmp_cond      = c;
        cmp_dst_true  = dt;
        cmp_dst_false = df;
        slot_qp       = {q1, q0};
        slot_wen_in   = w;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 R2: reset state checked while reset is still asserted
        drive(1'b0, 1'b0, 6'd0, 6'd0, 6'd0, 6'd40, 2'b11);
        check(2'b01, "R1_R2_in_reset", 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NVEC; k++) begin
            drive(VEC[k][29], VEC[k][28], VEC[k][27:22], VEC[k][21:16],
                  VEC[k][15:10], VEC[k][9:4], VEC[k][3:2]);
            check(VEC[k][1:0], "R1_R3_R4_R5_R6_R7_R8_R9_R10_vector", k);
        end

        // R2: flag 0 passes each raw enable pattern
        for (int w = 0; w < 4; w++) begin
            drive(1'b0, 1'b0, 6'd0, 6'd0, 6'd0, 6'd0, 2'(w));
            check(2'(w), "R2_zero_guard", w);
        end

        // R1: mid-run reset clears written flags p6, p7, p63
        drive(1'b0, 1'b0, 6'd0, 6'd0, 6'd6, 6'd7, 2'b11);
        check(2'b11, "R1_before_reset", 0);
        rst_n = 1'b0;
        #1;
        check(2'b00, "R1_async_clear", 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 1; i < NP; i++) begin
            drive(1'b0, 1'b0, 6'd0, 6'd0, 6'(i), 6'd0, 2'b11);
            check(2'b10, "R1_sweep_after_reset", i);
        end

        // R4 R10: top index written, neighbours untouched
        drive(1'b1, 1'b0, 6'd62, 6'd63, 6'd62, 6'd63, 2'b11);
        check(2'b00, "R6_top_index_old", 0);
        drive(1'b0, 1'b0, 6'd0, 6'd0, 6'd62, 6'd63, 2'b11);
        check(2'b10, "R4_top_index", 0);
        drive(1'b0, 1'b0, 6'd0, 6'd0, 6'd61, 6'd1, 2'b11);
        check(2'b00, "R10_neighbours", 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule